// File: doc/BRIEF.md
# Cluster Power State Legality Monitor

The monitor watches the supply-on flags and the retention and isolation controls of a processor cluster. It works out the abstract power state of every domain in the cluster. The cluster holds a number of CPU domains, each paired with a SIMD domain. It also holds one L2 domain and the enclosing cluster domain. A leaf domain's state depends on its own supply and controls. A parent domain's state is a conjunction over its own supply and the states of its children. Any combination that none of the defined states describes is flagged illegal.

The inputs are sampled once per clock. Every state code and the combinational illegal indication follow one cycle after the inputs. A sticky error register then records that an illegal combination was seen, together with the kind of violation, until software-side logic pulses a clear. The block sits beside the power controller as a run-time guard and never drives any control itself.

Top module: `pwr_state_monitor`

## Requirements
- R1: Each SIMD domain reports RUN (code 00) when its supply is on. When the supply is off it reports RET (01) if its hold input is high, and SHD (10) otherwise. A SIMD domain always matches a state.
- R2: A CPU domain reports RUN (00) when all of these hold: its supply is on, its SIMD is RUN, and its retention request and isolation enable are both low.
- R3: A CPU domain reports SHD (10) when its supply is off and its SIMD is SHD. It reports RET (01) when its supply is off, its SIMD is RET, and its retention request and isolation enable are both high.
- R4: A CPU domain that matches neither R2 nor R3 reports code 11, and its known bit is low. A CPU that matches has its known bit high.
- R5: The L2 domain reports RUN (00) when its supply is on and SHD (10) when it is off.
- R6: The cluster reports one of three states, each needing every CPU to be known: RUN (00) when its supply is on, L2 is RUN and every CPU is RUN; DMT (11) when its supply is off, L2 is RUN and every CPU is SHD; SHD (10) when its supply is off, L2 is SHD and every CPU is SHD. The cluster known bit is high in these three cases.
- R7: A cluster combination outside R6 drives cluster known low and cluster code 11.
- R8: `illegal` is high when any CPU is unknown or the cluster is unknown. It is also high for the forbidden combination: cluster supply on, L2 supply on, and some CPU with supply off, retention request and isolation high, while its SIMD supply is on.
- R9: All state codes, known bits and `illegal` reflect the inputs sampled at the previous rising clock edge.
- R10: `err_sticky` goes high on the edge after a cycle in which `illegal` is high. It stays high until an edge where `clr_err` is high. A new violation at that same edge keeps it set.
- R11: `err_cause[0]` records an unknown-state violation and `err_cause[1]` records a forbidden-combination violation. Both bits set and clear under the same rules as R10.
- R12: After reset the sampled inputs are all zero. Every domain then reads SHD with its known bit high, and `illegal`, `err_sticky` and `err_cause` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears the sticky error and cause bits |
| clu_pwr_on | input | 1 | Cluster supply on |
| l2_pwr_on | input | 1 | L2 supply on |
| cpu_pwr_on | input | NUM_CPU | Per-CPU supply on |
| simd_pwr_on | input | NUM_CPU | Per-SIMD supply on |
| simd_hold | input | NUM_CPU | Per-SIMD retention hold |
| cpu_ret_req | input | NUM_CPU | Per-CPU retention request |
| cpu_iso_en | input | NUM_CPU | Per-CPU output isolation enable |
| simd_state | output | 2*NUM_CPU | SIMD state codes, CPU i at bits 2i+1:2i |
| cpu_state | output | 2*NUM_CPU | CPU state codes, CPU i at bits 2i+1:2i |
| cpu_known | output | NUM_CPU | CPU matches a defined state |
| l2_state | output | 2 | L2 state code |
| clu_state | output | 2 | Cluster state code |
| clu_known | output | 1 | Cluster matches a defined state |
| illegal | output | 1 | Current sampled combination is illegal |
| err_sticky | output | 1 | Registered sticky error |
| err_cause | output | 2 | Sticky cause: bit0 unknown state, bit1 forbidden combination |

## Verification
The bench builds the monitor with NUM_CPU set to 2. With two CPUs the cluster conjunction can be tested on mixed cases: one CPU is RUN while the other is SHD, or one is in retention while its sibling is off. It also reaches the case where the forbidden combination comes from the second CPU rather than the first. Random stimulus is biased toward the three legal cluster states, so the clear and re-set behaviour of the sticky register is exercised often. Raw random patterns are mixed in to cover the unknown states.

// File: rtl/pwr_state_pkg.sv
// Package: state codes shared by the power state monitor and its checker.
// Assumes every domain state fits in a 2-bit code; 11 doubles as "no match"
// for domains that have no DMT state.
package pwr_state_pkg;
    localparam logic [1:0] PS_RUN   = 2'b00;
    localparam logic [1:0] PS_RET   = 2'b01;
    localparam logic [1:0] PS_SHD   = 2'b10;
    localparam logic [1:0] PS_DMT   = 2'b11;
    localparam logic [1:0] PS_NONE  = 2'b11;
endpackage

// File: rtl/pwr_leaf_decode.sv
// Module: decodes one CPU/SIMD pair from sampled supply and control bits.
// Assumes the inputs are already registered; purely combinational.
module pwr_leaf_decode
    import pwr_state_pkg::*;
(
    input  logic       simd_on,
    input  logic       simd_hold,
    input  logic       cpu_on,
    input  logic       ret_req,
    input  logic       iso_en,
    output logic [1:0] simd_st,
    output logic [1:0] cpu_st,
    output logic       cpu_ok,
    output logic       ret_over_live
);
    logic ctl_both;
    logic ctl_none;

    // Purpose: classify the retention and isolation controls.
    always_comb begin
        ctl_both = ret_req & iso_en;
        ctl_none = ~ret_req & ~iso_en;
    end

    // Purpose: SIMD state from supply and hold.
    always_comb begin
        if (simd_on)        simd_st = PS_RUN;
        else if (simd_hold) simd_st = PS_RET;
        else                simd_st = PS_SHD;
    end

    // Purpose: CPU state as a conjunction of own supply, controls and SIMD state.
    always_comb begin
        cpu_st = PS_NONE;
        cpu_ok = 1'b0;
        if (cpu_on && simd_st == PS_RUN && ctl_none) begin
            cpu_st = PS_RUN;
            cpu_ok = 1'b1;
        end else if (!cpu_on && simd_st == PS_SHD) begin
            cpu_st = PS_SHD;
            cpu_ok = 1'b1;
        end else if (!cpu_on && simd_st == PS_RET && ctl_both) begin
            cpu_st = PS_RET;
            cpu_ok = 1'b1;
        end
    end

    // Purpose: raw term for the forbidden retained-CPU-with-live-SIMD pattern.
    always_comb begin
        ret_over_live = ~cpu_on & ctl_both & simd_on;
    end
endmodule

// File: rtl/pwr_cluster_decode.sv
// Module: decodes L2 and cluster states from their supplies and the CPU states,
// and classifies the two kinds of violation. Purely combinational.
module pwr_cluster_decode
    import pwr_state_pkg::*;
#(
    parameter int NUM_CPU = 1
) (
    input  logic                   clu_on,
    input  logic                   l2_on,
    input  logic [2*NUM_CPU-1:0]   cpu_st,
    input  logic [NUM_CPU-1:0]     cpu_ok,
    input  logic [NUM_CPU-1:0]     ret_over_live,
    output logic [1:0]             l2_st,
    output logic [1:0]             clu_st,
    output logic                   clu_ok,
    output logic                   undef,
    output logic                   forbid
);
    logic [NUM_CPU-1:0] is_run;
    logic [NUM_CPU-1:0] is_shd;
    logic               all_run;
    logic               all_shd;

    // Purpose: per-CPU RUN and SHD flags, only for CPUs that matched.
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cls
        assign is_run[i] = cpu_ok[i] & (cpu_st[2*i +: 2] == PS_RUN);
        assign is_shd[i] = cpu_ok[i] & (cpu_st[2*i +: 2] == PS_SHD);
    end

    // Purpose: reduce the per-CPU flags.
    always_comb begin
        all_run = &is_run;
        all_shd = &is_shd;
    end

    // Purpose: L2 state from its supply.
    always_comb begin
        l2_st = l2_on ? PS_RUN : PS_SHD;
    end

    // Purpose: cluster state as a conjunction of supply, L2 and all CPUs.
    always_comb begin
        clu_st = PS_NONE;
        clu_ok = 1'b0;
        if (clu_on && l2_on && all_run) begin
            clu_st = PS_RUN;
            clu_ok = 1'b1;
        end else if (!clu_on && l2_on && all_shd) begin
            clu_st = PS_DMT;
            clu_ok = 1'b1;
        end else if (!clu_on && !l2_on && all_shd) begin
            clu_st = PS_SHD;
            clu_ok = 1'b1;
        end
    end

    // Purpose: violation classes.
    always_comb begin
        undef  = ~clu_ok | ~(&cpu_ok);
        forbid = clu_on & l2_on & (|ret_over_live);
    end
endmodule

// File: rtl/pwr_err_track.sv
// Module: sticky error and cause register. Set has priority over clear.
// Assumes undef/forbid are stable before the clock edge.
module pwr_err_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       undef,
    input  logic       forbid,
    output logic       err,
    output logic [1:0] cause
);
    // Purpose: accumulate violation kinds until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= 2'b00;
        end else begin
            cause[0] <= undef  | (cause[0] & ~clr);
            cause[1] <= forbid | (cause[1] & ~clr);
        end
    end

    // Purpose: summary sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= undef | forbid | (err & ~clr);
    end
endmodule

// File: rtl/pwr_state_monitor.sv
// Module: top of the cluster power state legality monitor. Samples all
// supply and control inputs, decodes every domain and tracks violations.
// Assumes inputs are synchronous to clk.
module pwr_state_monitor
    import pwr_state_pkg::*;
#(
    parameter int NUM_CPU = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_err,
    input  logic                 clu_pwr_on,
    input  logic                 l2_pwr_on,
    input  logic [NUM_CPU-1:0]   cpu_pwr_on,
    input  logic [NUM_CPU-1:0]   simd_pwr_on,
    input  logic [NUM_CPU-1:0]   simd_hold,
    input  logic [NUM_CPU-1:0]   cpu_ret_req,
    input  logic [NUM_CPU-1:0]   cpu_iso_en,
    output logic [2*NUM_CPU-1:0] simd_state,
    output logic [2*NUM_CPU-1:0] cpu_state,
    output logic [NUM_CPU-1:0]   cpu_known,
    output logic [1:0]           l2_state,
    output logic [1:0]           clu_state,
    output logic                 clu_known,
    output logic                 illegal,
    output logic                 err_sticky,
    output logic [1:0]           err_cause
);
    localparam int SW = 2 * NUM_CPU;

    logic               s_clu_on;
    logic               s_l2_on;
    logic [NUM_CPU-1:0] s_cpu_on;
    logic [NUM_CPU-1:0] s_simd_on;
    logic [NUM_CPU-1:0] s_hold;
    logic [NUM_CPU-1:0] s_rreq;
    logic [NUM_CPU-1:0] s_iso;
    logic [NUM_CPU-1:0] ret_live;
    logic [SW-1:0]      cpu_st_w;
    logic               undef_w;
    logic               forbid_w;

    // Purpose: sample every input once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_clu_on  <= 1'b0;
            s_l2_on   <= 1'b0;
            s_cpu_on  <= '0;
            s_simd_on <= '0;
            s_hold    <= '0;
            s_rreq    <= '0;
            s_iso     <= '0;
        end else begin
            s_clu_on  <= clu_pwr_on;
            s_l2_on   <= l2_pwr_on;
            s_cpu_on  <= cpu_pwr_on;
            s_simd_on <= simd_pwr_on;
            s_hold    <= simd_hold;
            s_rreq    <= cpu_ret_req;
            s_iso     <= cpu_iso_en;
        end
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_leaf
        pwr_leaf_decode u_leaf (
            .simd_on       (s_simd_on[i]),
            .simd_hold     (s_hold[i]),
            .cpu_on        (s_cpu_on[i]),
            .ret_req       (s_rreq[i]),
            .iso_en        (s_iso[i]),
            .simd_st       (simd_state[2*i +: 2]),
            .cpu_st        (cpu_st_w[2*i +: 2]),
            .cpu_ok        (cpu_known[i]),
            .ret_over_live (ret_live[i])
        );
    end

    assign cpu_state = cpu_st_w;

    pwr_cluster_decode #(.NUM_CPU(NUM_CPU)) u_clu (
        .clu_on        (s_clu_on),
        .l2_on         (s_l2_on),
        .cpu_st        (cpu_st_w),
        .cpu_ok        (cpu_known),
        .ret_over_live (ret_live),
        .l2_st         (l2_state),
        .clu_st        (clu_state),
        .clu_ok        (clu_known),
        .undef         (undef_w),
        .forbid        (forbid_w)
    );

    // Purpose: combined illegal indication.
    always_comb begin
        illegal = undef_w | forbid_w;
    end

    pwr_err_track u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_err),
        .undef  (undef_w),
        .forbid (forbid_w),
        .err    (err_sticky),
        .cause  (err_cause)
    );
endmodule

// File: rtl/pwr_state_monitor_checker.sv
// Module: property checker for pwr_state_monitor, attached by bind.
module pwr_state_monitor_checker
    import pwr_state_pkg::*;
#(
    parameter int NUM_CPU = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_err,
    input logic [2*NUM_CPU-1:0] simd_state,
    input logic [2*NUM_CPU-1:0] cpu_state,
    input logic [NUM_CPU-1:0]   cpu_known,
    input logic [1:0]           l2_state,
    input logic [1:0]           clu_state,
    input logic                 clu_known,
    input logic                 illegal,
    input logic                 err_sticky,
    input logic [1:0]           err_cause
);
    a_r10_set_after_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> err_sticky);

    a_r10_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !clr_err) |=> err_sticky);

    a_r10_clear_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !illegal) |=> !err_sticky);

    a_r11_cause_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cause != 2'b00) == err_sticky);

    a_r7_unknown_is_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !clu_known |-> illegal);

    a_r6_run_needs_l2_run: assert property (@(posedge clk) disable iff (!rst_n)
        (clu_known && clu_state == PS_RUN) |-> (l2_state == PS_RUN && (&cpu_known)));

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
        a_r2_cpu_run_needs_simd_run: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_known[i] && cpu_state[2*i +: 2] == PS_RUN) |-> simd_state[2*i +: 2] == PS_RUN);
        a_r3_cpu_ret_needs_simd_ret: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_known[i] && cpu_state[2*i +: 2] == PS_RET) |-> simd_state[2*i +: 2] == PS_RET);
        a_r4_unknown_cpu_code: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_known[i] |-> (cpu_state[2*i +: 2] == PS_NONE && illegal));
    end
endmodule

bind pwr_state_monitor pwr_state_monitor_checker #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_err    (clr_err),
    .simd_state (simd_state),
    .cpu_state  (cpu_state),
    .cpu_known  (cpu_known),
    .l2_state   (l2_state),
    .clu_state  (clu_state),
    .clu_known  (clu_known),
    .illegal    (illegal),
    .err_sticky (err_sticky),
    .err_cause  (err_cause)
);

// File: tb/pwr_state_monitor_bench.sv
module pwr_state_monitor_bench;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_err = 1'b0;
    logic clu_on = 1'b0, l2_on = 1'b0;
    logic [N-1:0] cpu_on = '0, simd_on = '0, hold = '0, rreq = '0, iso = '0;

    logic [2*N-1:0] simd_state, cpu_state;
    logic [N-1:0]   cpu_known;
    logic [1:0]     l2_state, clu_state, err_cause;
    logic           clu_known, illegal, err_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected model state
    logic [1:0] e_simd [N];
    logic [1:0] e_cpu [N];
    logic [N-1:0] e_cknown;
    logic [1:0] e_l2, e_clu;
    logic e_kclu, e_undef, e_forbid;
    logic m_undef = 1'b0, m_forbid = 1'b0;
    logic m_err = 1'b0;
    logic [1:0] m_cause = 2'b00;

    always #5 clk = ~clk;

    pwr_state_monitor #(.NUM_CPU(N)) u_pwr_state_monitor (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
        .clu_pwr_on(clu_on), .l2_pwr_on(l2_on), .cpu_pwr_on(cpu_on),
        .simd_pwr_on(simd_on), .simd_hold(hold), .cpu_ret_req(rreq),
        .cpu_iso_en(iso), .simd_state(simd_state), .cpu_state(cpu_state),
        .cpu_known(cpu_known), .l2_state(l2_state), .clu_state(clu_state),
        .clu_known(clu_known), .illegal(illegal), .err_sticky(err_sticky),
        .err_cause(err_cause)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected states from the requirement text (R1..R8).
    task automatic compute_exp();
        logic all_run, all_shd, rol;
        all_run = 1'b1; all_shd = 1'b1; rol = 1'b0;
        for (int i = 0; i < N; i++) begin
            e_simd[i] = simd_on[i] ? 2'b00 : (hold[i] ? 2'b01 : 2'b10);
            e_cpu[i] = 2'b11; e_cknown[i] = 1'b0;
            if (cpu_on[i] && simd_on[i] && !rreq[i] && !iso[i]) begin
                e_cpu[i] = 2'b00; e_cknown[i] = 1'b1;
            end else if (!cpu_on[i] && !simd_on[i] && !hold[i]) begin
                e_cpu[i] = 2'b10; e_cknown[i] = 1'b1;
            end else if (!cpu_on[i] && !simd_on[i] && hold[i] && rreq[i] && iso[i]) begin
                e_cpu[i] = 2'b01; e_cknown[i] = 1'b1;
            end
            if (!(e_cknown[i] && e_cpu[i] == 2'b00)) all_run = 1'b0;
            if (!(e_cknown[i] && e_cpu[i] == 2'b10)) all_shd = 1'b0;
            if (!cpu_on[i] && rreq[i] && iso[i] && simd_on[i]) rol = 1'b1;
        end
        e_l2 = l2_on ? 2'b00 : 2'b10;
        e_clu = 2'b11; e_kclu = 1'b0;
        if (clu_on && l2_on && all_run)        begin e_clu = 2'b00; e_kclu = 1'b1; end
        else if (!clu_on && l2_on && all_shd)  begin e_clu = 2'b11; e_kclu = 1'b1; end
        else if (!clu_on && !l2_on && all_shd) begin e_clu = 2'b10; e_kclu = 1'b1; end
        e_undef = !e_kclu || !(&e_cknown);
        e_forbid = clu_on && l2_on && rol;
    endtask

    task automatic check_all();
        for (int i = 0; i < N; i++) begin
            chk("R1 simd", {2'b0, simd_state[2*i +: 2]}, {2'b0, e_simd[i]});
            chk("R2/R3/R4 cpu", {1'b0, cpu_known[i], cpu_state[2*i +: 2]}, {1'b0, e_cknown[i], e_cpu[i]});
        end
        chk("R5 l2", {2'b0, l2_state}, {2'b0, e_l2});
        chk("R6/R7 cluster", {1'b0, clu_known, clu_state}, {1'b0, e_kclu, e_clu});
        chk("R8 illegal", {3'b0, illegal}, {3'b0, e_undef | e_forbid});
        chk("R10 sticky", {3'b0, err_sticky}, {3'b0, m_err});
        chk("R11 cause", {2'b0, err_cause}, {2'b0, m_cause});
    endtask

    // Apply current stimulus with clear bit c; check one cycle later (R9).
    task automatic step(input logic c);
        clr_err = c;
        @(posedge clk);
        m_err = m_undef | m_forbid | (m_err & ~c);
        m_cause[0] = m_undef | (m_cause[0] & ~c);
        m_cause[1] = m_forbid | (m_cause[1] & ~c);
        compute_exp();
        m_undef = e_undef;
        m_forbid = e_forbid;
        @(negedge clk);
        check_all();
        clr_err = 1'b0;
    endtask

    task automatic set_all(input logic c, input logic l, input logic [N-1:0] co,
                           input logic [N-1:0] so, input logic [N-1:0] h,
                           input logic [N-1:0] r, input logic [N-1:0] s);
        clu_on = c; l2_on = l; cpu_on = co; simd_on = so; hold = h; rreq = r; iso = s;
    endtask

    initial begin
        void'($urandom(32'd20250917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state, all sampled inputs zero
        compute_exp();
        chk("R12 reset cluster", {1'b0, clu_known, clu_state}, 4'b0110);
        chk("R12 reset cpu", {2'b0, cpu_known}, 4'b0011);
        chk("R12 reset err", {1'b0, err_sticky, err_cause}, 4'b0000);
        chk("R12 reset illegal", {3'b0, illegal}, 4'b0000);
        // R6 all RUN
        set_all(1, 1, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00); step(0);
        chk("R9 R6 run code", {2'b0, clu_state}, 4'b0000);
        // R6 DMT
        set_all(0, 1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00); step(0);
        chk("R6 dmt", {1'b0, clu_known, clu_state}, 4'b0111);
        // R3 CPU1 retention: CPU RET, cluster unknown (R7)
        set_all(0, 1, 2'b00, 2'b00, 2'b10, 2'b10, 2'b10); step(0);
        chk("R3 cpu1 ret", {2'b0, cpu_state[3:2]}, 4'b0001);
        step(0);
        chk("R10 sticky set", {3'b0, err_sticky}, 4'b0001);
        // R10 set wins over clear: still illegal while clearing
        step(1);
        chk("R10 set beats clear", {3'b0, err_sticky}, 4'b0001);
        // back to legal, clear next
        set_all(0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00); step(1);
        step(1);
        chk("R10 cleared", {1'b0, err_sticky, err_cause}, 4'b0000);
        // R8 forbidden combo from CPU1
        set_all(1, 1, 2'b01, 2'b11, 2'b00, 2'b10, 2'b10); step(0);
        step(0);
        chk("R11 forbid cause", {2'b0, err_cause}, 4'b0011);
        set_all(0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00); step(1); step(1);
        // R2 RUN blocked by isolation on a live CPU
        set_all(1, 1, 2'b11, 2'b11, 2'b00, 2'b00, 2'b01); step(0);
        chk("R4 cpu0 iso run", {3'b0, cpu_known[0]}, 4'b0000);
        // R1 hold ignored when SIMD supply on
        set_all(1, 1, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00); step(0);
        chk("R1 hold ignored", {2'b0, simd_state[1:0]}, 4'b0000);
        // mixed: one RUN one SHD with cluster on
        set_all(1, 1, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00); step(0);
        chk("R7 mixed", {3'b0, clu_known}, 4'b0000);
        step(1); step(1);
        // random phase
        for (int k = 0; k < 600; k++) begin
            int mode;
            mode = int'($urandom % 5);
            case (mode)
                0: set_all(1, 1, 2'b11, 2'b11, N'($urandom), 2'b00, 2'b00);
                1: set_all(0, 1, 2'b00, 2'b00, 2'b00, N'($urandom), N'($urandom));
                2: set_all(0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
                default: set_all(1'($urandom), 1'($urandom), N'($urandom), N'($urandom),
                                 N'($urandom), N'($urandom), N'($urandom));
            endcase
            step(($urandom % 6) == 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule